// File: doc/BRIEF.md
# Multi-Level Interrupt Dispatch Controller

This block decides, on a one-cycle request strobe, whether the currently pending interrupt level may be taken. When it is taken, the block performs the processor state update in the same clock edge. The take rule compares the requested level with the interrupt-level field of the status word and with the number of configured levels. It also requires a non-zero overlap between that level's interrupt mask and the pending and enabled interrupt lines.

Levels 2 and above each own a saved-PC and a saved-status register. Their entry raises the status interrupt level to the requested value and jumps to a per-level vector. Level 1 uses the general exception path instead. It records a cause code and selects the kernel or the user vector. If exception mode is already active, it escalates to a double exception, which saves the PC into a dedicated register when one is configured. Every vector can be relocated relative to a run-time vector base.

The status word and the saved registers live in a small register file inside the block. The surrounding pipeline can overwrite the status word through a write port.

Top module: `irq_dispatch`

## Requirements
- R1: After reset, the status word, new PC, cause, all saved-PC and saved-status registers, the double-exception PC and the taken strobe all read zero.
- R2: A request at level L with 2 <= L <= NUM_LEVELS that is taken stores the incoming PC in saved-PC slot L and the old status word in saved-status slot L. It sets status bits [3:0] to L and bit 4 (exception mode) to 1, keeps the other status bits, and loads the new PC with the level vector LVL_VEC_BASE + L*VEC_STRIDE.
- R3: A request whose level is not greater than status bits [3:0] is not taken and changes no state.
- R4: A request at level 0, or at a level above NUM_LEVELS, is not taken and changes no state.
- R5: A request is not taken when the AND of the level's mask, the interrupt-set word and the interrupt-enable word is zero.
- R6: A taken level-1 request with status bit 4 clear and bit 5 (user mode) clear writes cause code 4, stores the PC in saved-PC slot 1 and sets status bit 4. It leaves status bits [3:0] unchanged and jumps to KERNEL_VEC.
- R7: The same request with status bit 5 set behaves as R6 but jumps to USER_VEC.
- R8: A taken level-1 request with status bit 4 already set is a double exception. It writes cause 4, jumps to DOUBLE_VEC, and stores the PC in the double-exception PC register when HAS_DEPC is set, otherwise in saved-PC slot 1.
- R9: With relocation enabled, every target equals the configured vector minus DEF_VBASE plus the vector-base input.
- R10: The taken strobe is high for exactly the cycle after each edge at which a request was taken, and only then. The kind output then reports 0 for level 2 and above, 1 for kernel, 2 for user and 3 for double.
- R11: With the request strobe low, no dispatch state changes, whatever the other inputs hold.
- R12: A status write lands at the next edge when no request is taken. In the same cycle as a taken request, the dispatch update wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | One-cycle dispatch request strobe |
| lvl_i | input | 4 | Pending interrupt level |
| lmask_i | input | (NUM_LEVELS+1)*NUM_INTS | Per-level interrupt mask table, level L at bits [L*NUM_INTS +: NUM_INTS] |
| iset_i | input | NUM_INTS | Interrupt-set word |
| ien_i | input | NUM_INTS | Interrupt-enable word |
| pc_i | input | XLEN | Current program counter |
| vbase_i | input | XLEN | Run-time vector base |
| ps_wr_i | input | 1 | Status word write strobe |
| ps_wdata_i | input | XLEN | Status word write data |
| taken_o | output | 1 | Dispatch taken strobe |
| kind_o | output | 2 | Kind of entry last taken |
| pc_o | output | XLEN | New program counter (vector target) |
| ps_o | output | XLEN | Status word |
| epc_o | output | NUM_LEVELS*XLEN | Saved-PC slots 1..NUM_LEVELS, slot L at [(L-1)*XLEN +: XLEN] |
| eps_o | output | NUM_LEVELS*XLEN | Saved-status slots, same layout, slot 1 reads zero |
| depc_o | output | XLEN | Double-exception PC |
| cause_o | output | 6 | Exception cause |

## Verification
A status write from the pipeline and a taken dispatch can arrive on the same edge. Both want to write the status word, and the dispatch must win. The bench provokes this both in directed steps and in a random phase. Directed steps assert the write strobe together with a qualifying request, and also with one that is rejected. The random phase raises both strobes independently. A behavioural model applies the priority rule on its own, and every cycle it compares the status word and all saved registers, so a dropped dispatch or a leaked write shows up at once.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
   typedef enum logic [1:0] {
      VK_HILVL  = 2'd0,
      VK_KERNEL = 2'd1,
      VK_USER   = 2'd2,
      VK_DOUBLE = 2'd3
   } vec_kind_e;

   localparam int LVL_W    = 4;
   localparam int PS_EXCM  = 4;
   localparam int PS_UM    = 5;
   localparam int CAUSE_W  = 6;
   localparam logic [CAUSE_W-1:0] CAUSE_LVL1_IRQ = 6'd4;
endpackage

// File: rtl/irq_take_gate.sv
module irq_take_gate
   import irq_disp_pkg::*;
#(
   parameter int NUM_INTS   = 16,
   parameter int NUM_LEVELS = 6
) (
   input  logic [LVL_W-1:0]                   lvl_i,
   input  logic [LVL_W-1:0]                   cur_lvl_i,
   input  logic [(NUM_LEVELS+1)*NUM_INTS-1:0] lmask_i,
   input  logic [NUM_INTS-1:0]                iset_i,
   input  logic [NUM_INTS-1:0]                ien_i,
   output logic                               take_o
);
   logic [NUM_INTS-1:0] sel_mask;
   logic                in_range;
   logic                above_cur;
   logic                unused_lvl0;

   // slice 0 of the table has no meaning: level 0 is never taken
   assign unused_lvl0 = ^lmask_i[NUM_INTS-1:0];

   always_comb begin
      sel_mask = '0;
      for (int l = 1; l <= NUM_LEVELS; l++) begin
         if (lvl_i == LVL_W'(l)) sel_mask = lmask_i[l*NUM_INTS +: NUM_INTS];
      end
   end

   assign in_range  = (lvl_i != '0) && (lvl_i <= LVL_W'(NUM_LEVELS));
   assign above_cur = lvl_i > cur_lvl_i;
   assign take_o    = in_range && above_cur && |(sel_mask & iset_i & ien_i);
endmodule

// File: rtl/irq_vec_map.sv
module irq_vec_map
   import irq_disp_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter bit              RELOC_EN     = 1'b1,
   parameter logic [XLEN-1:0] DEF_VBASE    = 32'h4000_0000,
   parameter logic [XLEN-1:0] LVL_VEC_BASE = 32'h4000_0100,
   parameter logic [XLEN-1:0] VEC_STRIDE   = 32'h0000_0020,
   parameter logic [XLEN-1:0] KERNEL_VEC   = 32'h4000_0300,
   parameter logic [XLEN-1:0] USER_VEC     = 32'h4000_0340,
   parameter logic [XLEN-1:0] DOUBLE_VEC   = 32'h4000_03C0
) (
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             excm_i,
   input  logic             um_i,
   input  logic [XLEN-1:0]  vbase_i,
   output vec_kind_e        kind_o,
   output logic [XLEN-1:0]  target_o
);
   logic [XLEN-1:0] raw_vec;
   logic [XLEN-1:0] lvl_ext;

   assign lvl_ext = {{(XLEN-LVL_W){1'b0}}, lvl_i};

   always_comb begin
      if (lvl_i > LVL_W'(1)) begin
         kind_o  = VK_HILVL;
         raw_vec = LVL_VEC_BASE + lvl_ext * VEC_STRIDE;
      end else if (excm_i) begin
         kind_o  = VK_DOUBLE;
         raw_vec = DOUBLE_VEC;
      end else if (um_i) begin
         kind_o  = VK_USER;
         raw_vec = USER_VEC;
      end else begin
         kind_o  = VK_KERNEL;
         raw_vec = KERNEL_VEC;
      end
   end

   generate
      if (RELOC_EN) begin : g_reloc
         assign target_o = raw_vec - DEF_VBASE + vbase_i;
      end else begin : g_fixed
         logic unused_vbase;
         assign unused_vbase = ^vbase_i;
         assign target_o     = raw_vec;
      end
   endgenerate
endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
   import irq_disp_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NUM_LEVELS = 6,
   parameter bit HAS_DEPC   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       take_i,
   input  logic [LVL_W-1:0]           lvl_i,
   input  vec_kind_e                  kind_i,
   input  logic [XLEN-1:0]            target_i,
   input  logic [XLEN-1:0]            pc_i,
   input  logic                       ps_wr_i,
   input  logic [XLEN-1:0]            ps_wdata_i,
   output logic [XLEN-1:0]            ps_o,
   output logic [XLEN-1:0]            pc_o,
   output logic                       taken_o,
   output logic [1:0]                 kind_o,
   output logic [NUM_LEVELS*XLEN-1:0] epc_o,
   output logic [NUM_LEVELS*XLEN-1:0] eps_o,
   output logic [XLEN-1:0]            depc_o,
   output logic [CAUSE_W-1:0]         cause_o
);
   localparam bit DBL_TO_EPC1 = !HAS_DEPC;

   logic [XLEN-1:0]    ps_q;
   logic [XLEN-1:0]    pc_q;
   logic               taken_q;
   vec_kind_e          kind_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [XLEN-1:0]    epc_q [1:NUM_LEVELS];
   logic [XLEN-1:0]    eps_q [2:NUM_LEVELS];
   logic               save_epc1;

   assign save_epc1 = (kind_i == VK_KERNEL) || (kind_i == VK_USER) ||
                      ((kind_i == VK_DOUBLE) && DBL_TO_EPC1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q    <= '0;
         pc_q    <= '0;
         taken_q <= 1'b0;
         kind_q  <= VK_HILVL;
         cause_q <= '0;
         for (int l = 1; l <= NUM_LEVELS; l++) epc_q[l] <= '0;
         for (int l = 2; l <= NUM_LEVELS; l++) eps_q[l] <= '0;
      end else begin
         taken_q <= take_i;
         if (take_i) begin
            pc_q   <= target_i;
            kind_q <= kind_i;
            if (kind_i == VK_HILVL) begin
               for (int l = 2; l <= NUM_LEVELS; l++) begin
                  if (lvl_i == LVL_W'(l)) begin
                     epc_q[l] <= pc_i;
                     eps_q[l] <= ps_q;
                  end
               end
               ps_q <= {ps_q[XLEN-1:PS_EXCM+1], 1'b1, lvl_i};
            end else begin
               cause_q       <= CAUSE_LVL1_IRQ;
               ps_q[PS_EXCM] <= 1'b1;
               if (save_epc1) epc_q[1] <= pc_i;
            end
         end else if (ps_wr_i) begin
            ps_q <= ps_wdata_i;
         end
      end
   end

   generate
      if (HAS_DEPC) begin : g_depc
         logic [XLEN-1:0] depc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              depc_q <= '0;
            else if (take_i && kind_i == VK_DOUBLE)  depc_q <= pc_i;
         end
         assign depc_o = depc_q;
      end else begin : g_no_depc
         assign depc_o = '0;
      end

      for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_flat
         assign epc_o[(l-1)*XLEN +: XLEN] = epc_q[l];
         if (l == 1) begin : g_eps_none
            assign eps_o[(l-1)*XLEN +: XLEN] = '0;
         end else begin : g_eps
            assign eps_o[(l-1)*XLEN +: XLEN] = eps_q[l];
         end
      end
   endgenerate

   assign ps_o    = ps_q;
   assign pc_o    = pc_q;
   assign taken_o = taken_q;
   assign kind_o  = kind_q;
   assign cause_o = cause_q;

   // R6
   excm_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> ps_q[PS_EXCM]);

   // R2
   hilvl_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && kind_i == VK_HILVL) |=> ps_q[LVL_W-1:0] == $past(lvl_i));

   // R8
   double_from_excm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && kind_i == VK_DOUBLE) |-> ps_q[PS_EXCM]);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_i && !ps_wr_i) |=> ($stable(ps_q) && $stable(pc_q) && $stable(cause_q)));

   // R12
   write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && ps_wr_i && kind_i == VK_HILVL) |=> ps_q[PS_EXCM]);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_disp_pkg::*;
#(
   parameter int              XLEN         = 32,
   parameter int              NUM_INTS     = 16,
   parameter int              NUM_LEVELS   = 6,
   parameter bit              HAS_DEPC     = 1'b1,
   parameter bit              RELOC_EN     = 1'b1,
   parameter logic [XLEN-1:0] DEF_VBASE    = 32'h4000_0000,
   parameter logic [XLEN-1:0] LVL_VEC_BASE = 32'h4000_0100,
   parameter logic [XLEN-1:0] VEC_STRIDE   = 32'h0000_0020,
   parameter logic [XLEN-1:0] KERNEL_VEC   = 32'h4000_0300,
   parameter logic [XLEN-1:0] USER_VEC     = 32'h4000_0340,
   parameter logic [XLEN-1:0] DOUBLE_VEC   = 32'h4000_03C0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               req_i,
   input  logic [3:0]                         lvl_i,
   input  logic [(NUM_LEVELS+1)*NUM_INTS-1:0] lmask_i,
   input  logic [NUM_INTS-1:0]                iset_i,
   input  logic [NUM_INTS-1:0]                ien_i,
   input  logic [XLEN-1:0]                    pc_i,
   input  logic [XLEN-1:0]                    vbase_i,
   input  logic                               ps_wr_i,
   input  logic [XLEN-1:0]                    ps_wdata_i,
   output logic                               taken_o,
   output logic [1:0]                         kind_o,
   output logic [XLEN-1:0]                    pc_o,
   output logic [XLEN-1:0]                    ps_o,
   output logic [NUM_LEVELS*XLEN-1:0]         epc_o,
   output logic [NUM_LEVELS*XLEN-1:0]         eps_o,
   output logic [XLEN-1:0]                    depc_o,
   output logic [5:0]                         cause_o
);
   generate
      if (NUM_LEVELS < 2 || NUM_LEVELS > 15) begin : g_bad_levels
         $error("irq_dispatch: NUM_LEVELS must lie in 2..15");
      end
      if (XLEN < PS_UM + 1) begin : g_bad_xlen
         $error("irq_dispatch: XLEN too narrow for the status word");
      end
      if (NUM_INTS < 1) begin : g_bad_ints
         $error("irq_dispatch: NUM_INTS must be at least 1");
      end
   endgenerate

   logic            gate_take;
   logic            take_w;
   vec_kind_e       kind_w;
   logic [XLEN-1:0] target_w;

   irq_take_gate #(
      .NUM_INTS   (NUM_INTS),
      .NUM_LEVELS (NUM_LEVELS)
   ) u_gate (
      .lvl_i     (lvl_i),
      .cur_lvl_i (ps_o[LVL_W-1:0]),
      .lmask_i   (lmask_i),
      .iset_i    (iset_i),
      .ien_i     (ien_i),
      .take_o    (gate_take)
   );

   assign take_w = req_i && gate_take;

   irq_vec_map #(
      .XLEN         (XLEN),
      .RELOC_EN     (RELOC_EN),
      .DEF_VBASE    (DEF_VBASE),
      .LVL_VEC_BASE (LVL_VEC_BASE),
      .VEC_STRIDE   (VEC_STRIDE),
      .KERNEL_VEC   (KERNEL_VEC),
      .USER_VEC     (USER_VEC),
      .DOUBLE_VEC   (DOUBLE_VEC)
   ) u_vec (
      .lvl_i    (lvl_i),
      .excm_i   (ps_o[PS_EXCM]),
      .um_i     (ps_o[PS_UM]),
      .vbase_i  (vbase_i),
      .kind_o   (kind_w),
      .target_o (target_w)
   );

   irq_state_regs #(
      .XLEN       (XLEN),
      .NUM_LEVELS (NUM_LEVELS),
      .HAS_DEPC   (HAS_DEPC)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take_w),
      .lvl_i      (lvl_i),
      .kind_i     (kind_w),
      .target_i   (target_w),
      .pc_i       (pc_i),
      .ps_wr_i    (ps_wr_i),
      .ps_wdata_i (ps_wdata_i),
      .ps_o       (ps_o),
      .pc_o       (pc_o),
      .taken_o    (taken_o),
      .kind_o     (kind_o),
      .epc_o      (epc_o),
      .eps_o      (eps_o),
      .depc_o     (depc_o),
      .cause_o    (cause_o)
   );

   // R10
   taken_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o |-> $past(req_i));

   // R4
   range_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_w |-> (lvl_i != 4'd0 && lvl_i <= 4'(NUM_LEVELS)));

   // R3
   above_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_w |-> lvl_i > ps_o[LVL_W-1:0]);
endmodule

// File: tb/sim_irq_dispatch.sv
`timescale 1ns/1ps
module sim_irq_dispatch;
   localparam int NL = 6;
   localparam int NI = 16;
   localparam logic [31:0] DEFB = 32'h4000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic [3:0] lvl = '0;
   logic [(NL+1)*NI-1:0] lmask = '0;
   logic [NI-1:0] iset = '0, ien = '0;
   logic [31:0] pc = '0, vbase = DEFB;
   logic ps_wr = 1'b0;
   logic [31:0] ps_wd = '0;
   logic taken;
   logic [1:0] kind;
   logic [31:0] pc_o, ps_o, depc;
   logic [NL*32-1:0] epc, eps;
   logic [5:0] cause;

   irq_dispatch u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_i(lvl), .lmask_i(lmask),
      .iset_i(iset), .ien_i(ien), .pc_i(pc), .vbase_i(vbase),
      .ps_wr_i(ps_wr), .ps_wdata_i(ps_wd), .taken_o(taken), .kind_o(kind),
      .pc_o(pc_o), .ps_o(ps_o), .epc_o(epc), .eps_o(eps), .depc_o(depc),
      .cause_o(cause)
   );

   always #2 clk = ~clk;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   logic [31:0] m_ps = '0, m_pc = '0, m_depc = '0;
   logic [5:0]  m_cause = '0;
   logic        m_taken = 1'b0;
   logic [1:0]  m_kind = '0;
   logic [31:0] m_epc [1:NL];
   logic [31:0] m_eps [1:NL];

   task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      check("taken", {31'd0, taken}, {31'd0, m_taken});
      check("ps", ps_o, m_ps);
      check("pc", pc_o, m_pc);
      check("cause", {26'd0, cause}, {26'd0, m_cause});
      check("depc", depc, m_depc);
      if (m_taken) check("kind", {30'd0, kind}, {30'd0, m_kind});
      for (int l = 1; l <= NL; l++) begin
         check($sformatf("epc%0d", l), epc[(l-1)*32 +: 32], m_epc[l]);
         check($sformatf("eps%0d", l), eps[(l-1)*32 +: 32], m_eps[l]);
      end
   endtask

   function automatic logic [31:0] vec_of(input int k, input int l, input logic [31:0] vb);
      logic [31:0] raw;
      case (k)
         0: raw = 32'h4000_0100 + 32'(l) * 32'h20;
         1: raw = 32'h4000_0300;
         2: raw = 32'h4000_0340;
         default: raw = 32'h4000_03C0;
      endcase
      return raw - DEFB + vb;
   endfunction

   task automatic step(input bit rq, input int lv, input logic [NI-1:0] is_v,
                       input logic [NI-1:0] ie_v, input logic [31:0] pcv,
                       input logic [31:0] vb, input bit wr, input logic [31:0] wd);
      bit ok;
      int k;
      logic [NI-1:0] msk;
      @(negedge clk);
      compare();
      req = rq; lvl = 4'(lv); iset = is_v; ien = ie_v; pc = pcv; vbase = vb;
      ps_wr = wr; ps_wd = wd;
      msk = (lv >= 1 && lv <= NL) ? lmask[lv*NI +: NI] : '0;
      ok = rq && lv >= 1 && lv <= NL && lv > int'(m_ps[3:0]) && ((msk & is_v & ie_v) != 0);
      m_taken = ok;
      if (ok) begin
         if (lv > 1) k = 0;
         else if (m_ps[4]) k = 3;
         else if (m_ps[5]) k = 2;
         else k = 1;
         m_kind = 2'(k);
         m_pc = vec_of(k, lv, vb);
         if (k == 0) begin
            m_epc[lv] = pcv;
            m_eps[lv] = m_ps;
            m_ps = (m_ps & ~32'h1F) | 32'h10 | 32'(lv);
         end else begin
            m_cause = 6'd4;
            if (k == 3) m_depc = pcv;
            else m_epc[1] = pcv;
            m_ps = m_ps | 32'h10;
         end
      end else if (wr) begin
         m_ps = wd;
      end
   endtask

   task automatic idle();
      step(0, 0, '0, '0, 32'h0, DEFB, 0, 32'h0);
   endtask

   task automatic wr_ps(input logic [31:0] v);
      step(0, 0, '0, '0, 32'h0, DEFB, 1, v);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int l = 1; l <= NL; l++) begin m_epc[l] = '0; m_eps[l] = '0; end
      for (int l = 1; l <= NL; l++) lmask[l*NI +: NI] = NI'(1) << l;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_req = "R1";
      idle();
      // R2: climb through every high level
      cur_req = "R2";
      for (int l = 2; l <= NL; l++) step(1, l, '1, '1, 32'h1000 + 32'(l), DEFB, 0, 0);
      idle();
      // R3: at or below the current level
      cur_req = "R3";
      step(1, 5, '1, '1, 32'h2000, DEFB, 0, 0);
      step(1, NL, '1, '1, 32'h2004, DEFB, 0, 0);
      idle();
      // R4: out of range levels
      wr_ps(32'h0);
      cur_req = "R4";
      step(1, 0, '1, '1, 32'h2100, DEFB, 0, 0);
      step(1, 7, '1, '1, 32'h2104, DEFB, 0, 0);
      step(1, 15, '1, '1, 32'h2108, DEFB, 0, 0);
      idle();
      // R5: empty mask product
      cur_req = "R5";
      step(1, 3, '1, '0, 32'h2200, DEFB, 0, 0);
      step(1, 3, 16'h0001, '1, 32'h2204, DEFB, 0, 0);
      idle();
      // R6: level 1 kernel
      cur_req = "R6";
      step(1, 1, '1, '1, 32'h3000, DEFB, 0, 0);
      idle();
      // R7: level 1 user
      wr_ps(32'h20);
      cur_req = "R7";
      step(1, 1, '1, '1, 32'h3100, DEFB, 0, 0);
      idle();
      // R8: level 1 with exception mode set
      cur_req = "R8";
      step(1, 1, '1, '1, 32'h3200, DEFB, 0, 0);
      idle();
      // R9: relocated vectors
      wr_ps(32'h0);
      cur_req = "R9";
      step(1, 4, '1, '1, 32'h3300, 32'h6000_0000, 0, 0);
      wr_ps(32'h0);
      step(1, 1, '1, '1, 32'h3304, 32'h0800_0000, 0, 0);
      idle();
      // R11: request low with otherwise valid inputs
      wr_ps(32'h0);
      cur_req = "R11";
      step(0, 2, '1, '1, 32'h3400, DEFB, 0, 0);
      step(0, 1, '1, '1, 32'h3404, DEFB, 0, 0);
      idle();
      // R12: write coinciding with a taken and a rejected request
      cur_req = "R12";
      step(1, 2, '1, '1, 32'h3500, DEFB, 1, 32'h0000_0025);
      step(1, 2, '1, '1, 32'h3504, DEFB, 1, 32'h0000_0021);
      idle();
      // R10: back-to-back requests
      wr_ps(32'h0);
      cur_req = "R10";
      step(1, 2, '1, '1, 32'h3600, DEFB, 0, 0);
      step(1, 3, '1, '1, 32'h3604, DEFB, 0, 0);
      step(1, 3, '1, '1, 32'h3608, DEFB, 0, 0);
      idle();
      // random mix of requests and writes
      cur_req = "R12";
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0], int'(r[4:1]) % 8, NI'($urandom), NI'($urandom), $urandom,
              r[5] ? 32'h6000_0000 : DEFB, r[8:6] == 3'd0,
              {26'd0, r[12:9] == 4'd0, 1'b0, 4'($urandom_range(0, 6))});
      end
      idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule